// File: doc/BRIEF.md
# Collision-Free Cache Line Group Builder

This controller runs once after a built-in self-test has recorded, for every cache line, a vector with one bit per chunk that is set where the chunk holds a failing cell. It sorts the lines into groups so that no two lines in a group have a failing chunk in the same position. Each group then needs only one spare line: the spare gives up its own contents to supply the healthy chunks that the other members lack. The controller reads the fault vectors through a simple asynchronous read port and walks the lines one at a time.

Group building is greedy and follows ascending line index. A line with no failing chunk is marked as a standalone data line and joins no group. A line with faults is tested against the open groups in the order they were opened. It joins the first group whose accumulated fault union shares no set bit with it, provided that group still has room. If no group accepts it, the line opens a new group and becomes that group's spare. Once every line is placed, the controller writes one memory-map entry per line and one fault-map entry per group. It then reports done. If more groups are needed than the fault map can hold, it reports done with the fail flag set and writes no map entries. Status holds until the next start.

Top module: `gbld_group_builder`

## Requirements
- R1: During and after reset, until the first start, busy, done and fail are low and neither map write strobe is asserted.
- R2: No two lines given the same group index with a non-standalone role have fault vectors whose bitwise AND is nonzero.
- R3: Lines are placed in ascending index order. A faulty line joins the lowest-numbered open group whose fault union ANDed with its vector is zero and whose member count is below MAX_MEMBERS, and it gets role code 2'b01 (data). If no group accepts it, it opens group number equal to the current group count and gets role code 2'b10 (spare). Each group therefore has exactly one spare, and that spare is its lowest-indexed member.
- R4: No group holds more than MAX_MEMBERS lines, counting its spare.
- R5: A line whose fault vector is all zero gets role code 2'b00 (standalone) and group index 0, and it changes no group.
- R6: On success, the memory map is written once for every line, in ascending line order on consecutive cycles (mm_we with mm_addr, mm_grp, mm_role). Role code 2'b11 never appears.
- R7: After the last memory-map write, the fault map is written once per group, in ascending group order on consecutive cycles. Each fm_vec is the OR of the fault vectors of that group's members.
- R8: Let S be the line-placement cycles. S adds 1 cycle per line, plus 1 cycle per group compared for a faulty line (including the group it joins), plus 1 more cycle when the line opens a new group. On success, done rises S + NUM_LINES + G clock edges after the edge that samples start, where G is the group count. busy is high in between.
- R9: If a line must open a group while MAX_GROUPS groups already exist, the controller stops with done and fail high and makes no map write in that run.
- R10: A start pulse that arrives while busy is high is ignored and does not change the result or the timing.
- R11: done and fail hold their values until a start is sampled outside a run. On that edge both drop and busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a build when not busy |
| fv_addr | output | $clog2(NUM_LINES) | Line index for the fault-vector read |
| fv_data | input | CHUNKS | Fault vector of line fv_addr, valid in the same cycle |
| busy | output | 1 | Build in progress |
| done | output | 1 | Build finished (success or fail) |
| fail | output | 1 | Group count exceeded MAX_GROUPS; maps not written |
| mm_we | output | 1 | Memory-map write strobe |
| mm_addr | output | $clog2(NUM_LINES) | Line index being written |
| mm_grp | output | $clog2(MAX_GROUPS) | Group of that line |
| mm_role | output | 2 | 00 standalone, 01 data, 10 spare |
| fm_we | output | 1 | Fault-map write strobe |
| fm_addr | output | $clog2(MAX_GROUPS) | Group index being written |
| fm_vec | output | CHUNKS | Fault union of that group |

## Verification
The builder is driven with several fault patterns, each chosen to separate one behaviour. An all-clean array checks the standalone path and the case with no fault-map writes. A rotating one-hot pattern makes groups fill up, so the member cap decides where lines go. A single shared faulty chunk in every line forces overflow and the fail path. Sparse random patterns exercise the greedy choice across many different collision layouts, and dense random patterns drive group counts near and past capacity. Every result is compared with an arithmetic model of the greedy rule, cycle count included. Independently of that model, the captured maps are checked pairwise for collisions, for exactly one spare per group, and for each fault-map entry matching the OR of its group's members.

// File: rtl/gbld_pkg.sv
package gbld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ASSIGN,
        ST_WR_LINE,
        ST_WR_GRP,
        ST_DONE,
        ST_FAIL
    } gb_state_e;

    typedef enum logic [1:0] {
        ROLE_SOLO  = 2'b00,
        ROLE_DATA  = 2'b01,
        ROLE_SPARE = 2'b10
    } gb_role_e;

endpackage

// File: rtl/gbld_fit_check.sv
// Decides whether a line may join one candidate group.
module gbld_fit_check #(
    parameter int CHUNKS      = 8,
    parameter int MAX_MEMBERS = 4,
    localparam int CW = $clog2(MAX_MEMBERS + 1)
) (
    input  logic [CHUNKS-1:0] grp_union,
    input  logic [CW-1:0]     grp_count,
    input  logic [CHUNKS-1:0] line_vec,
    output logic              fits
);
    logic overlap;
    logic has_room;

    always_comb begin
        overlap  = |(grp_union & line_vec);
        has_room = grp_count < CW'(MAX_MEMBERS);
        fits     = !overlap && has_room;
    end
endmodule

// File: rtl/gbld_group_table.sv
// Per-group fault union and member count.
module gbld_group_table #(
    parameter int CHUNKS      = 8,
    parameter int MAX_GROUPS  = 8,
    parameter int MAX_MEMBERS = 4,
    localparam int GW = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
    localparam int CW = $clog2(MAX_MEMBERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic              add_open,
    input  logic [GW-1:0]     add_idx,
    input  logic [CHUNKS-1:0] add_vec,
    input  logic [GW-1:0]     rd_idx,
    output logic [CHUNKS-1:0] rd_union,
    output logic [CW-1:0]     rd_count
);
    logic [CHUNKS-1:0] union_d [MAX_GROUPS];
    logic [CHUNKS-1:0] union_q [MAX_GROUPS];
    logic [CW-1:0]     count_d [MAX_GROUPS];
    logic [CW-1:0]     count_q [MAX_GROUPS];

    always_comb begin
        for (int g = 0; g < MAX_GROUPS; g++) begin
            union_d[g] = union_q[g];
            count_d[g] = count_q[g];
            if (add_en && (int'(add_idx) == g)) begin
                if (add_open) begin
                    union_d[g] = add_vec;
                    count_d[g] = CW'(1);
                end else begin
                    union_d[g] = union_q[g] | add_vec;
                    count_d[g] = count_q[g] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < MAX_GROUPS; g++) begin
            if (!rst_n) begin
                union_q[g] <= '0;
                count_q[g] <= '0;
            end else begin
                union_q[g] <= union_d[g];
                count_q[g] <= count_d[g];
            end
        end
    end

    always_comb begin
        rd_union = '0;
        rd_count = '0;
        if (int'(rd_idx) < MAX_GROUPS) begin
            rd_union = union_q[rd_idx];
            rd_count = count_q[rd_idx];
        end
    end
endmodule

// File: rtl/gbld_line_table.sv
// Per-line placement result: group index and role code.
module gbld_line_table #(
    parameter int NUM_LINES  = 16,
    parameter int MAX_GROUPS = 8,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int GW = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [GW-1:0] wr_grp,
    input  logic [1:0]    wr_role,
    input  logic [LW-1:0] rd_idx,
    output logic [GW-1:0] rd_grp,
    output logic [1:0]    rd_role
);
    logic [GW-1:0] grp_d  [NUM_LINES];
    logic [GW-1:0] grp_q  [NUM_LINES];
    logic [1:0]    role_d [NUM_LINES];
    logic [1:0]    role_q [NUM_LINES];

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) begin
            grp_d[l]  = grp_q[l];
            role_d[l] = role_q[l];
            if (wr_en && (int'(wr_idx) == l)) begin
                grp_d[l]  = wr_grp;
                role_d[l] = wr_role;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < NUM_LINES; l++) begin
            if (!rst_n) begin
                grp_q[l]  <= '0;
                role_q[l] <= '0;
            end else begin
                grp_q[l]  <= grp_d[l];
                role_q[l] <= role_d[l];
            end
        end
    end

    always_comb begin
        rd_grp  = '0;
        rd_role = '0;
        if (int'(rd_idx) < NUM_LINES) begin
            rd_grp  = grp_q[rd_idx];
            rd_role = role_q[rd_idx];
        end
    end
endmodule

// File: rtl/gbld_group_builder.sv
// Top: sequencer for scan, greedy placement and map programming.
module gbld_group_builder
    import gbld_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int CHUNKS      = 8,
    parameter int MAX_MEMBERS = 4,
    parameter int MAX_GROUPS  = 8,
    localparam int LW  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int GW  = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
    localparam int GCW = $clog2(MAX_GROUPS + 1),
    localparam int CW  = $clog2(MAX_MEMBERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [LW-1:0]     fv_addr,
    input  logic [CHUNKS-1:0] fv_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              mm_we,
    output logic [LW-1:0]     mm_addr,
    output logic [GW-1:0]     mm_grp,
    output logic [1:0]        mm_role,
    output logic              fm_we,
    output logic [GW-1:0]     fm_addr,
    output logic [CHUNKS-1:0] fm_vec
);
    localparam logic [LW-1:0]  LAST_LINE = LW'(NUM_LINES - 1);
    localparam logic [GCW-1:0] GRP_CAP   = GCW'(MAX_GROUPS);

    typedef struct packed {
        gb_state_e         st;
        logic [LW-1:0]     line;
        logic [GCW-1:0]    cand;
        logic [GCW-1:0]    ngrp;
        logic [CHUNKS-1:0] vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              gt_add_en;
    logic              gt_add_open;
    logic [GW-1:0]     gt_add_idx;
    logic [CHUNKS-1:0] gt_union;
    logic [CW-1:0]     gt_count;
    logic              cand_fits;

    logic              lt_wr_en;
    logic [GW-1:0]     lt_wr_grp;
    logic [1:0]        lt_wr_role;
    logic [GW-1:0]     lt_rd_grp;
    logic [1:0]        lt_rd_role;

    gbld_group_table #(
        .CHUNKS     (CHUNKS),
        .MAX_GROUPS (MAX_GROUPS),
        .MAX_MEMBERS(MAX_MEMBERS)
    ) u_groups (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (gt_add_en),
        .add_open(gt_add_open),
        .add_idx (gt_add_idx),
        .add_vec (ctl_q.vec),
        .rd_idx  (ctl_q.cand[GW-1:0]),
        .rd_union(gt_union),
        .rd_count(gt_count)
    );

    gbld_fit_check #(
        .CHUNKS     (CHUNKS),
        .MAX_MEMBERS(MAX_MEMBERS)
    ) u_fit (
        .grp_union(gt_union),
        .grp_count(gt_count),
        .line_vec (ctl_q.vec),
        .fits     (cand_fits)
    );

    gbld_line_table #(
        .NUM_LINES (NUM_LINES),
        .MAX_GROUPS(MAX_GROUPS)
    ) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lt_wr_en),
        .wr_idx (ctl_q.line),
        .wr_grp (lt_wr_grp),
        .wr_role(lt_wr_role),
        .rd_idx (ctl_q.line),
        .rd_grp (lt_rd_grp),
        .rd_role(lt_rd_role)
    );

    // Next-state and table-control logic.
    always_comb begin
        ctl_d       = ctl_q;
        gt_add_en   = 1'b0;
        gt_add_open = 1'b0;
        gt_add_idx  = ctl_q.cand[GW-1:0];
        lt_wr_en    = 1'b0;
        lt_wr_grp   = '0;
        lt_wr_role  = ROLE_SOLO;

        unique case (ctl_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    ctl_d.st   = ST_SCAN;
                    ctl_d.line = '0;
                    ctl_d.cand = '0;
                    ctl_d.ngrp = '0;
                    ctl_d.vec  = '0;
                end
            end

            ST_SCAN: begin
                ctl_d.vec  = fv_data;
                ctl_d.cand = '0;
                if (fv_data == '0) begin
                    lt_wr_en   = 1'b1;
                    lt_wr_role = ROLE_SOLO;
                    if (ctl_q.line == LAST_LINE) begin
                        ctl_d.st   = ST_WR_LINE;
                        ctl_d.line = '0;
                    end else begin
                        ctl_d.line = ctl_q.line + LW'(1);
                    end
                end else begin
                    ctl_d.st = ST_ASSIGN;
                end
            end

            ST_ASSIGN: begin
                if (ctl_q.cand == ctl_q.ngrp) begin
                    if (ctl_q.ngrp == GRP_CAP) begin
                        ctl_d.st = ST_FAIL;
                    end else begin
                        gt_add_en   = 1'b1;
                        gt_add_open = 1'b1;
                        gt_add_idx  = ctl_q.ngrp[GW-1:0];
                        lt_wr_en    = 1'b1;
                        lt_wr_grp   = ctl_q.ngrp[GW-1:0];
                        lt_wr_role  = ROLE_SPARE;
                        ctl_d.ngrp  = ctl_q.ngrp + GCW'(1);
                    end
                end else if (cand_fits) begin
                    gt_add_en  = 1'b1;
                    lt_wr_en   = 1'b1;
                    lt_wr_grp  = ctl_q.cand[GW-1:0];
                    lt_wr_role = ROLE_DATA;
                end else begin
                    ctl_d.cand = ctl_q.cand + GCW'(1);
                end

                if (lt_wr_en) begin
                    if (ctl_q.line == LAST_LINE) begin
                        ctl_d.st   = ST_WR_LINE;
                        ctl_d.line = '0;
                    end else begin
                        ctl_d.st   = ST_SCAN;
                        ctl_d.line = ctl_q.line + LW'(1);
                    end
                end
            end

            ST_WR_LINE: begin
                if (ctl_q.line == LAST_LINE) begin
                    ctl_d.cand = '0;
                    ctl_d.st   = (ctl_q.ngrp == '0) ? ST_DONE : ST_WR_GRP;
                end else begin
                    ctl_d.line = ctl_q.line + LW'(1);
                end
            end

            ST_WR_GRP: begin
                if (ctl_q.cand == ctl_q.ngrp - GCW'(1)) begin
                    ctl_d.st = ST_DONE;
                end else begin
                    ctl_d.cand = ctl_q.cand + GCW'(1);
                end
            end

            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, line: '0, cand: '0, ngrp: '0, vec: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Port outputs decoded from registered state.
    always_comb begin
        fv_addr = ctl_q.line;
        busy    = (ctl_q.st == ST_SCAN) || (ctl_q.st == ST_ASSIGN) ||
                  (ctl_q.st == ST_WR_LINE) || (ctl_q.st == ST_WR_GRP);
        done    = (ctl_q.st == ST_DONE) || (ctl_q.st == ST_FAIL);
        fail    = (ctl_q.st == ST_FAIL);
        mm_we   = (ctl_q.st == ST_WR_LINE);
        mm_addr = ctl_q.line;
        mm_grp  = lt_rd_grp;
        mm_role = lt_rd_role;
        fm_we   = (ctl_q.st == ST_WR_GRP);
        fm_addr = ctl_q.cand[GW-1:0];
        fm_vec  = gt_union;
    end
endmodule

// File: rtl/gbld_checker.sv
module gbld_checker #(
    parameter int NUM_LINES  = 16,
    parameter int CHUNKS     = 8,
    parameter int MAX_GROUPS = 8,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int GW = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              mm_we,
    input logic [LW-1:0]     mm_addr,
    input logic [GW-1:0]     mm_grp,
    input logic [1:0]        mm_role,
    input logic              fm_we,
    input logic [GW-1:0]     fm_addr,
    input logic [CHUNKS-1:0] fm_vec
);
    AST_ONE_MAP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(mm_we && fm_we)); // R6

    AST_MM_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we && $past(mm_we)) |-> (mm_addr == LW'($past(mm_addr) + 1'b1))); // R6

    AST_ROLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mm_we |-> (mm_role != 2'b11)); // R6

    AST_SOLO_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we && mm_role == 2'b00) |-> (mm_grp == '0)); // R5

    AST_FM_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_we && $past(fm_we)) |-> (fm_addr == GW'($past(fm_addr) + 1'b1))); // R7

    AST_FM_AFTER_MM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fm_we) |-> ($past(mm_we) && fm_addr == '0)); // R7

    AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!mm_we && !fm_we && done)); // R9

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && fail == $past(fail))); // R11

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (busy && !done && !fail)); // R11
endmodule

bind gbld_group_builder gbld_checker #(
    .NUM_LINES (NUM_LINES),
    .CHUNKS    (CHUNKS),
    .MAX_GROUPS(MAX_GROUPS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .fail   (fail),
    .mm_we  (mm_we),
    .mm_addr(mm_addr),
    .mm_grp (mm_grp),
    .mm_role(mm_role),
    .fm_we  (fm_we),
    .fm_addr(fm_addr),
    .fm_vec (fm_vec)
);

// File: tb/sim_gbld_group_builder.sv
`timescale 1ns/1ps
module sim_gbld_group_builder;
    localparam int NL = 16;
    localparam int CH = 8;
    localparam int MM = 4;
    localparam int MG = 8;
    localparam int LW = $clog2(NL);
    localparam int GW = $clog2(MG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] fv_addr;
    logic [CH-1:0] fv_data;
    logic          busy, done, fail;
    logic          mm_we, fm_we;
    logic [LW-1:0] mm_addr;
    logic [GW-1:0] mm_grp, fm_addr;
    logic [1:0]    mm_role;
    logic [CH-1:0] fm_vec;

    logic [CH-1:0] fmem [NL];
    assign fv_data = fmem[fv_addr];

    always #5 clk = ~clk;

    gbld_group_builder #(.NUM_LINES(NL), .CHUNKS(CH), .MAX_MEMBERS(MM), .MAX_GROUPS(MG)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fv_addr(fv_addr), .fv_data(fv_data),
        .busy(busy), .done(done), .fail(fail),
        .mm_we(mm_we), .mm_addr(mm_addr), .mm_grp(mm_grp), .mm_role(mm_role),
        .fm_we(fm_we), .fm_addr(fm_addr), .fm_vec(fm_vec)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Captured map writes.
    int            c_mm_n  [NL];
    int            c_grp   [NL];
    int            c_role  [NL];
    int            c_fm_n  [MG];
    logic [CH-1:0] c_fm    [MG];

    always @(negedge clk) begin
        if (mm_we) begin
            c_mm_n[mm_addr]++;
            c_grp[mm_addr]  = int'(mm_grp);
            c_role[mm_addr] = int'(mm_role);
        end
        if (fm_we) begin
            c_fm_n[fm_addr]++;
            c_fm[fm_addr] = fm_vec;
        end
    end

    // Arithmetic model of the greedy rule.
    int            m_grp  [NL];
    int            m_role [NL];
    int            m_cnt  [MG];
    logic [CH-1:0] m_un   [MG];
    int            m_ng, m_T;
    bit            m_fail;

    task automatic model();
        m_ng = 0; m_T = 0; m_fail = 1'b0;
        for (int l = 0; l < NL; l++) begin
            int joined;
            m_T++;
            m_grp[l] = 0; m_role[l] = 0;
            if (fmem[l] == '0) continue;
            joined = -1;
            for (int g = 0; g < m_ng; g++) begin
                m_T++;
                if (((m_un[g] & fmem[l]) == '0) && (m_cnt[g] < MM)) begin
                    joined = g;
                    break;
                end
            end
            if (joined >= 0) begin
                m_un[joined] |= fmem[l];
                m_cnt[joined]++;
                m_grp[l] = joined; m_role[l] = 1;
            end else begin
                m_T++;
                if (m_ng == MG) begin
                    m_fail = 1'b1;
                    break;
                end
                m_un[m_ng] = fmem[l]; m_cnt[m_ng] = 1;
                m_grp[l] = m_ng; m_role[l] = 2;
                m_ng++;
            end
        end
        if (!m_fail) m_T += NL + m_ng;
    endtask

    task automatic run_case(input string nm, input bit poke);
        int n;
        model();
        for (int l = 0; l < NL; l++) begin c_mm_n[l] = 0; c_grp[l] = -1; c_role[l] = -1; end
        for (int g = 0; g < MG; g++) begin c_fm_n[g] = 0; c_fm[g] = '0; end
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(busy && !done && !fail, {"R11 start clears status ", nm}, {busy, done, fail}, 3'b100);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            start = (poke && n == 3) ? 1'b1 : 1'b0;
            if (done || n > 4000) break;
        end
        start = 1'b0;
        chk(fail == m_fail, {"R9 fail flag ", nm}, fail, m_fail);
        if (m_fail) begin
            int wr;
            wr = 0;
            for (int l = 0; l < NL; l++) wr += c_mm_n[l];
            for (int g = 0; g < MG; g++) wr += c_fm_n[g];
            chk(wr == 0, {"R9 no map writes on fail ", nm}, wr, 0);
        end else begin
            chk(n == m_T, {poke ? "R10 " : "R8 ", "done timing ", nm}, n, m_T);
            for (int l = 0; l < NL; l++) begin
                chk(c_mm_n[l] == 1, {"R6 one memory-map write per line ", nm}, c_mm_n[l], 1);
                chk(c_role[l] == m_role[l], {m_role[l] == 0 ? "R5" : "R3", " role ", nm}, c_role[l], m_role[l]);
                chk(c_grp[l] == m_grp[l], {m_role[l] == 0 ? "R5" : "R3", " group ", nm}, c_grp[l], m_grp[l]);
            end
            for (int g = 0; g < MG; g++) begin
                logic [CH-1:0] orv;
                int mem, spr;
                orv = '0; mem = 0; spr = 0;
                for (int l = 0; l < NL; l++) begin
                    if (c_role[l] != 0 && c_grp[l] == g) begin
                        orv |= fmem[l]; mem++;
                        if (c_role[l] == 2) spr++;
                        for (int k = l + 1; k < NL; k++)
                            if (c_role[k] != 0 && c_grp[k] == g)
                                chk((fmem[l] & fmem[k]) == '0, {"R2 collision in group ", nm}, int'(fmem[l] & fmem[k]), 0);
                    end
                end
                chk(c_fm_n[g] == ((g < m_ng) ? 1 : 0), {"R7 fault-map write count ", nm}, c_fm_n[g], (g < m_ng) ? 1 : 0);
                if (g < m_ng) begin
                    chk(c_fm[g] == orv, {"R7 fault-map union ", nm}, int'(c_fm[g]), int'(orv));
                    chk(spr == 1, {"R3 one spare per group ", nm}, spr, 1);
                    chk(mem <= MM, {"R4 group size cap ", nm}, mem, MM);
                end
            end
        end
        repeat (3) @(negedge clk);
        chk(done && !busy && fail == m_fail, {"R11 status holds ", nm}, {done, fail}, {1'b1, m_fail});
    endtask

    initial begin
        #(200000 * 10);
        nerr++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) fmem[l] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mm_we && !fm_we, "R1 quiet in reset", {busy, done, fail, mm_we, fm_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !fail && !mm_we && !fm_we, "R1 quiet after reset", {busy, done, fail, mm_we, fm_we}, 0);

        run_case("all clean", 1'b0);

        for (int l = 0; l < NL; l++) fmem[l] = CH'(1) << (l % CH);
        run_case("rotating one-hot", 1'b0);
        run_case("rotating one-hot with start during run", 1'b1);

        for (int l = 0; l < NL; l++) fmem[l] = CH'(1) << 3;
        run_case("shared chunk overflow", 1'b0);

        for (int r = 0; r < 12; r++) begin
            for (int l = 0; l < NL; l++)
                for (int b = 0; b < CH; b++)
                    fmem[l][b] = (($urandom % 10) == 0);
            run_case("sparse random", r == 5);
        end

        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < NL; l++)
                for (int b = 0; b < CH; b++)
                    fmem[l][b] = (($urandom % 3) == 0);
            run_case("dense random", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule